// File: doc/BRIEF.md
# Prescaled Interval Timer Bank

A bank of six independent down-counters, each driven by one of four shared tick inputs through a power-of-two prescaler. Software configures each channel through a control word, an interval value and a directly writable live counter. When a channel runs out, it raises a flag in a shared interrupt status register. In periodic mode the channel then reloads from its interval and keeps counting. In one-shot mode it stops and drops its own enable bit.

Each channel drives its own interrupt line. The line is the channel's status flag masked by its enable flag. Software clears status flags by writing ones to them. Register reads are combinational from the address, and writes take effect on the clock edge at which `wr_en` is high.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset the interrupt enable and status registers read 0, every interval and count reads 0, every control register reads 0x04 (tick source 1, all other fields 0), no channel counts, and `irq` is 0.
- R2: The interrupt enable register is at address 0x000 and the status register at 0x004. Channel k (0..5) occupies the slot at 0x10*(k+1): control at +0x0, interval at +0x4, live count at +0x8. Any other address reads 0, and a write to it changes no register.
- R3: Control bit 0 is enable, bit 1 is reload, bits [3:2] pick the tick source, bits [6:4] hold N and bit 7 selects one-shot. The reload bit always reads back as 0.
- R4: An enabled channel takes one count step per 2^N pulses of `src_tick[source]`. Pulses on the other tick inputs have no effect on the channel.
- R5: A step taken while the count is 2 or more lowers the count by 1. A channel whose enable bit is 0 holds its count whatever ticks arrive.
- R6: A step taken while the count is 0 or 1 is an expiry. It sets the channel's status bit (bit k). In periodic mode (bit 7 = 0) it loads the interval into the count, and the channel stays enabled.
- R7: In one-shot mode an expiry leaves the count at 0 and clears the channel's enable bit. Later ticks then have no effect.
- R8: A control write with bit 1 set copies the interval into the count and restarts the prescaler. A control write sets or clears the enable bit to match bit 0 of the written value.
- R9: Writing the count register loads that value into the live counter.
- R10: A status write clears each bit written as 1 and keeps each bit written as 0. An expiry of a channel in the same cycle as a write that clears that channel's bit leaves the bit set.
- R11: `irq[k]` is 1 exactly when status bit k and enable bit k are both 1. It follows a change to either register in the cycle after the write or expiry.
- R12: A control write to a channel in the cycle in which that channel would step discards the step: the count does not change and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | One-cycle tick pulses of the four selectable sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 6 | Per-channel interrupt lines |

## Verification
Two pairs of functions can collide in the same cycle. A software write that clears a status bit can meet that channel's expiry, and a control write can meet a pending count step. The bench provokes each collision by driving the status or control write and the selected tick pulse on the same clock edge, with the counter preset to 1 or 5. The expected outcome is that the expiry survives the clear, so the status flag stays set. For the control write, the step is lost, so the count is read back unchanged and no flag appears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_SRC  = 4;
    localparam int SRC_W    = 2;
    localparam int LOG2_W   = 3;
    localparam int CTRL_W   = 8;

    typedef struct packed {
        logic              oneshot;
        logic [LOG2_W-1:0] log2div;
        logic [SRC_W-1:0]  src;
        logic              reload;
        logic              en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{oneshot: 1'b0, log2div: '0, src: 2'd1,
                                     reload: 1'b0, en: 1'b0};

    localparam logic [7:0] IRQ_EN_ADDR = 8'h00;
    localparam logic [7:0] IRQ_ST_ADDR = 8'h04;

    typedef enum logic [3:0] {
        OFF_CTRL = 4'h0,
        OFF_INTV = 4'h4,
        OFF_CNT  = 4'h8
    } chan_off_e;

    function automatic ctrl_t to_ctrl(input logic [CTRL_W-1:0] raw);
        ctrl_t c;
        c = ctrl_t'(raw);
        c.reload = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              restart,
    input  logic              run,
    input  logic [LOG2_W-1:0] log2div,
    output logic              step
);
    localparam int DIV_W = (2 ** LOG2_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = (DIV_W'(1) << log2div) - DIV_W'(1);
        step = run && tick && (div_q == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= step ? '0 : div_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               ctrl_wr,
    input  logic               intv_wr,
    input  logic               cnt_wr,
    input  logic [DATA_W-1:0]  wdata,
    output ctrl_t              ctrl_q,
    output logic [DATA_W-1:0]  intv_q,
    output logic [DATA_W-1:0]  cnt_q,
    output logic               expire
);
    logic step;
    logic last;

    tmr_prescaler u_div (
        .clk     (clk),
        .rst     (rst),
        .tick    (src_tick[ctrl_q.src]),
        .restart (ctrl_wr),
        .run     (ctrl_q.en),
        .log2div (ctrl_q.log2div),
        .step    (step)
    );

    always_comb begin
        last   = (cnt_q <= DATA_W'(1));
        expire = step && ctrl_q.en && !ctrl_wr && !cnt_wr && last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            intv_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (intv_wr) begin
                intv_q <= wdata;
            end
            if (ctrl_wr) begin
                ctrl_q <= to_ctrl(wdata[CTRL_W-1:0]);
                if (wdata[1]) begin
                    cnt_q <= intv_q;
                end
            end else if (cnt_wr) begin
                cnt_q <= wdata;
            end else if (step && ctrl_q.en) begin
                if (!last) begin
                    cnt_q <= cnt_q - DATA_W'(1);
                end else if (ctrl_q.oneshot) begin
                    cnt_q     <= '0;
                    ctrl_q.en <= 1'b0;
                end else begin
                    cnt_q <= intv_q;
                end
            end
        end
    end

    p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_q.oneshot) |=> (!ctrl_q.en && cnt_q == '0));

    p_periodic_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (expire && !ctrl_q.oneshot) |=> (cnt_q == $past(intv_q) && ctrl_q.en));

    p_write_drops_step_r12: assert property (@(posedge clk) disable iff (rst)
        (step && ctrl_wr && !wdata[1]) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_wr,
    input  logic              st_wr,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] expire,
    output logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] st_q,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0] clr;

    always_comb begin
        clr = st_wr ? wbits : '0;
        irq = st_q & en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (en_wr) begin
                en_q <= wbits;
            end
            st_q <= (st_q & ~clr) | expire;
        end
    end

    p_w1c_r10: assert property (@(posedge clk) disable iff (rst)
        st_wr |=> ((st_q & $past(wbits & ~expire)) == '0));

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st_q & $past(st_q & ~clr)) == $past(st_q & ~clr)));

    p_expire_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (|expire) |=> ((st_q & $past(expire)) == $past(expire)));

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         src_tick,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [NUM_CH-1:0]  irq
);
    localparam int SLOT_W = 4;

    logic              low_page;
    logic [SLOT_W-1:0] slot;
    logic [3:0]        off;
    logic              en_hit;
    logic              st_hit;

    ctrl_t             ctrl_arr [NUM_CH];
    logic [DATA_W-1:0] intv_arr [NUM_CH];
    logic [DATA_W-1:0] cnt_arr  [NUM_CH];
    logic [NUM_CH-1:0] ctrl_wr, intv_wr, cnt_wr, expire;
    logic [NUM_CH-1:0] en_q, st_q;

    always_comb begin
        low_page = (addr[ADDR_W-1:8] == '0);
        slot     = addr[7:4];
        off      = addr[3:0];
        en_hit   = (addr == ADDR_W'(IRQ_EN_ADDR));
        st_hit   = (addr == ADDR_W'(IRQ_ST_ADDR));
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic hit;
        assign hit        = wr_en && low_page && (slot == SLOT_W'(k + 1));
        assign ctrl_wr[k] = hit && (off == OFF_CTRL);
        assign intv_wr[k] = hit && (off == OFF_INTV);
        assign cnt_wr[k]  = hit && (off == OFF_CNT);

        tmr_channel #(.DATA_W(DATA_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .src_tick (src_tick),
            .ctrl_wr  (ctrl_wr[k]),
            .intv_wr  (intv_wr[k]),
            .cnt_wr   (cnt_wr[k]),
            .wdata    (wdata),
            .ctrl_q   (ctrl_arr[k]),
            .intv_q   (intv_arr[k]),
            .cnt_q    (cnt_arr[k]),
            .expire   (expire[k])
        );
    end

    tmr_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .en_wr  (wr_en && en_hit),
        .st_wr  (wr_en && st_hit),
        .wbits  (wdata[NUM_CH-1:0]),
        .expire (expire),
        .en_q   (en_q),
        .st_q   (st_q),
        .irq    (irq)
    );

    always_comb begin
        rdata = '0;
        if (en_hit) begin
            rdata = DATA_W'(en_q);
        end else if (st_hit) begin
            rdata = DATA_W'(st_q);
        end else if (low_page) begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (slot == SLOT_W'(k + 1)) begin
                    case (off)
                        OFF_CTRL: rdata = DATA_W'(ctrl_arr[k]);
                        OFF_INTV: rdata = intv_arr[k];
                        OFF_CNT:  rdata = cnt_arr[k];
                        default:  rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: tb/tick_timer_bank_bench.sv
`timescale 1ns/1ps
module tick_timer_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  src_tick = '0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  irq;

    always #5 clk = ~clk;

    tick_timer_bank u_tick_timer_bank (
        .clk(clk), .rst(rst), .src_tick(src_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct {
        logic        is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    logic  probe = 1'b0;
    int    n_chk = 0;
    int    n_err = 0;
    logic  done  = 1'b0;

    initial forever begin
        @(negedge clk);
        #2;
        if (probe && sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? 32'(irq) : rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [3:0] t);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; src_tick = t;
        @(negedge clk);
        wr_en = 1'b0; src_tick = '0;
    endtask

    task automatic exp_rd(input logic [9:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        sb_q.push_back('{1'b0, e, tag});
        probe = 1'b1;
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic exp_irq(input logic [5:0] e, input string tag);
        @(negedge clk);
        sb_q.push_back('{1'b1, 32'(e), tag});
        probe = 1'b1;
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic ticks(input logic [3:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_tick = m;
        end
        @(negedge clk);
        src_tick = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        exp_rd(10'h000, 32'h0,  "R1 irq enable");
        exp_rd(10'h004, 32'h0,  "R1 status");
        exp_rd(10'h010, 32'h04, "R1 ctrl ch0");
        exp_rd(10'h014, 32'h0,  "R1 interval ch0");
        exp_rd(10'h018, 32'h0,  "R1 count ch0");
        exp_rd(10'h060, 32'h04, "R1 ctrl ch5");
        exp_irq(6'h00,          "R1 irq lines");

        // R2 undecoded addresses
        wr(10'h01C, 32'h5, 4'h0);
        wr(10'h070, 32'hFF, 4'h0);
        exp_rd(10'h01C, 32'h0,  "R2 hole read");
        exp_rd(10'h070, 32'h0,  "R2 slot7 read");
        exp_rd(10'h110, 32'h0,  "R2 high page read");
        exp_rd(10'h010, 32'h04, "R2 ctrl untouched");
        exp_rd(10'h018, 32'h0,  "R2 count untouched");

        // R3 R8 reload, R5 stopped
        wr(10'h014, 32'd3, 4'h0);
        wr(10'h010, 32'h06, 4'h0);
        exp_rd(10'h010, 32'h04, "R3 reload reads 0");
        exp_rd(10'h018, 32'd3,  "R8 reload copies interval");
        ticks(4'b0010, 2);
        exp_rd(10'h018, 32'd3,  "R5 disabled holds");

        // R4 R5 R6 periodic countdown
        wr(10'h010, 32'h05, 4'h0);
        exp_rd(10'h010, 32'h05, "R8 enable set");
        ticks(4'b0010, 1);
        exp_rd(10'h018, 32'd2,  "R5 decrement");
        ticks(4'b0001, 3);
        exp_rd(10'h018, 32'd2,  "R4 other source ignored");
        ticks(4'b0010, 1);
        exp_rd(10'h018, 32'd1,  "R5 decrement to 1");
        ticks(4'b0010, 1);
        exp_rd(10'h018, 32'd3,  "R6 periodic reload");
        exp_rd(10'h004, 32'h01, "R6 status set");
        exp_rd(10'h010, 32'h05, "R6 stays enabled");
        exp_irq(6'h00,          "R11 masked");
        wr(10'h000, 32'h01, 4'h0);
        exp_irq(6'h01,          "R11 unmasked");
        wr(10'h004, 32'h00, 4'h0);
        exp_rd(10'h004, 32'h01, "R10 zero keeps");
        wr(10'h004, 32'h01, 4'h0);
        exp_rd(10'h004, 32'h00, "R10 one clears");
        exp_irq(6'h00,          "R11 cleared");
        wr(10'h010, 32'h04, 4'h0);

        // R4 R7 prescaler and one-shot on ch1
        wr(10'h024, 32'd2, 4'h0);
        wr(10'h020, 32'hAB, 4'h0);
        exp_rd(10'h020, 32'hA9, "R3 ctrl fields");
        ticks(4'b0100, 3);
        exp_rd(10'h028, 32'd2,  "R4 under 2^N");
        ticks(4'b0100, 1);
        exp_rd(10'h028, 32'd1,  "R4 step at 2^N");
        ticks(4'b0100, 4);
        exp_rd(10'h028, 32'd0,  "R7 count zero");
        exp_rd(10'h020, 32'hA8, "R7 enable cleared");
        exp_rd(10'h004, 32'h02, "R6 status bit1");
        ticks(4'b0100, 8);
        exp_rd(10'h028, 32'd0,  "R7 stays stopped");
        exp_rd(10'h004, 32'h02, "R7 single expiry");
        wr(10'h004, 32'h02, 4'h0);

        // R9 count write on ch5
        wr(10'h068, 32'd10, 4'h0);
        exp_rd(10'h068, 32'd10, "R9 count load");
        wr(10'h060, 32'h01, 4'h0);
        ticks(4'b0001, 2);
        exp_rd(10'h068, 32'd8,  "R9 counts from loaded");

        // R10 clear collides with expiry
        wr(10'h000, 32'h20, 4'h0);
        wr(10'h068, 32'd1, 4'h0);
        wr(10'h004, 32'h20, 4'b0001);
        exp_rd(10'h004, 32'h20, "R10 expiry beats clear");
        exp_rd(10'h068, 32'd0,  "R6 reload zero interval");
        exp_irq(6'h20,          "R11 ch5 line");
        wr(10'h004, 32'h20, 4'h0);
        exp_rd(10'h004, 32'h00, "R10 clear later");

        // R12 control write drops step
        wr(10'h068, 32'd5, 4'h0);
        wr(10'h060, 32'h01, 4'b0001);
        exp_rd(10'h068, 32'd5,  "R12 step discarded");
        exp_rd(10'h004, 32'h00, "R12 no expiry");

        // R8 stop
        wr(10'h060, 32'h00, 4'h0);
        ticks(4'b0001, 2);
        exp_rd(10'h068, 32'd5,  "R8 stopped holds");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule